// File: doc/BRIEF.md
# Serial Bootstrap Loader with DMA Bus Master

This block lets a processor with no boot ROM start from an image sent over a serial line. When reset is released it asks the processor for its bus and waits for the grant. Once it owns the bus, every byte that arrives on the serial input is written into RAM, beginning at address zero and moving up by one location per byte. When the image length is reached, the block drops its bus request and turns off all of its bus drivers. The processor then runs its normal reset sequence and fetches its vectors from the image that was just loaded.

The same serial hardware stays useful after boot. A two-register port appears to software. Offset 0 is the data register: a read returns the last received byte and a write sends a byte. Offset 1 is the status register, which reports whether the transmitter is idle and whether a received byte is waiting. The line format is 8 data bits, no parity and one stop bit. Each bit lasts sixteen ticks of an internal oversampling clock, so the divider parameter sets the baud rate. At 100 MHz a divider of 54 gives about 115200 baud.

Top module: `boot_dma_loader`

## Requirements
- R1: While reset is held and until a grant arrives, `bus_req` is 1. `dma_oe`, `dma_as`, `dma_ds` and `dma_wr` are 0, and `txd` is 1.
- R2: `dma_oe` and the strobes (`dma_as`, `dma_ds`, `dma_wr`) are only ever high while `bus_grant` is high and before the load has finished.
- R3: The n-th accepted byte (counting from 0) is written with `dma_addr` = n and `dma_data` = that byte. The strobes are held for exactly STROBE_CYC cycles and then drop for at least one cycle before the next write. The address changes only while the strobes are low.
- R4: After IMAGE_LEN writes (255 by default), `bus_req` and `dma_oe` go to 0 and `boot_done` goes to 1, and all three stay there. Serial bytes that arrive later produce no bus write.
- R5: The receiver decodes 8N1 frames, LSB first, with 16x oversampling. A frame whose stop bit is 0 is discarded: it does not advance the load address and does not set receive-ready.
- R6: The transmitter sends 8N1 frames, LSB first. Each bit lasts 16*CLK_DIV clocks and the line idles at 1.
- R7: A read at `reg_addr`=1 returns bit 0 = transmitter empty, bit 1 = receive data ready, and 0 in bits 7:2. Receive-ready is set when a valid frame completes after boot.
- R8: `reg_rdata` at `reg_addr`=0 is the last byte received after boot. A read strobe (`reg_rd`) there clears receive-ready on the next clock.
- R9: A write strobe (`reg_wr`) at `reg_addr`=0 while the transmitter is empty starts a frame and clears transmitter-empty until the stop bit has been sent. A write while the transmitter is busy is ignored.
- R10: Bytes received during the load never set receive-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| bus_grant | input | 1 | Processor bus grant |
| bus_req | output | 1 | Bus request to the processor |
| dma_oe | output | 1 | Enable for the address, data and strobe drivers |
| dma_addr | output | ADDR_W | DMA write address |
| dma_data | output | 8 | DMA write data |
| dma_as | output | 1 | Address strobe, active high |
| dma_ds | output | 1 | Data strobe, active high |
| dma_wr | output | 1 | Write qualifier, active high |
| boot_done | output | 1 | Image loaded and bus released |
| reg_addr | input | 1 | Register select: 0 data, 1 status |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The image is 255 bytes from a stride-37 sequence that includes 0x00 and 0xFF. A bad-stop-bit frame is placed before the first byte, in the middle of the image and just before the last byte. This shows whether a framing error wrongly advances the address or shifts the data. Holding the grant back for a while after reset shows whether the block drives the bus before it owns it. After boot, a valid byte, a bad frame and two transmitted bytes (0x3C, then 0x81 with a write issued while busy) separate the status flags, the clear-on-read behaviour and the ignored write.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  typedef enum logic [2:0] {
    LD_REQ, LD_WAIT, LD_WRITE, LD_GAP, LD_DONE
  } ld_state_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;

  localparam int OVERSAMPLE = 16;
endpackage

// File: rtl/bootld_tick.sv
module bootld_tick #(
  parameter int DIV = 54
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));
  assign tick = wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bootld_rx.sv
module bootld_rx
  import bootld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data
);
  rx_state_e   st_q, st_d;
  logic        s1_q, s2_q;
  logic [3:0]  tc_q, tc_d;
  logic [2:0]  bn_q, bn_d;
  logic [7:0]  sh_q, sh_d;
  logic        arm_q, arm_d;
  logic        vld_q, vld_d;
  logic [7:0]  dat_q, dat_d;

  assign valid = vld_q;
  assign data  = dat_q;

  always_comb begin
    st_d  = st_q;
    tc_d  = tc_q;
    bn_d  = bn_q;
    sh_d  = sh_q;
    arm_d = arm_q;
    vld_d = 1'b0;
    dat_d = dat_q;
    unique case (st_q)
      RX_IDLE: begin
        if (s2_q) arm_d = 1'b1;
        if (tick && arm_q && !s2_q) begin
          st_d = RX_START;
          tc_d = '0;
        end
      end
      RX_START: if (tick) begin
        if (tc_q == 4'd7) begin
          tc_d = '0;
          bn_d = '0;
          st_d = s2_q ? RX_IDLE : RX_DATA;
        end else tc_d = tc_q + 1'b1;
      end
      RX_DATA: if (tick) begin
        if (tc_q == 4'(OVERSAMPLE - 1)) begin
          tc_d = '0;
          sh_d = {s2_q, sh_q[7:1]};
          if (bn_q == 3'd7) st_d = RX_STOP;
          else              bn_d = bn_q + 1'b1;
        end else tc_d = tc_q + 1'b1;
      end
      RX_STOP: if (tick) begin
        if (tc_q == 4'(OVERSAMPLE - 1)) begin
          if (s2_q) begin
            vld_d = 1'b1;
            dat_d = sh_q;
          end
          arm_d = 1'b0;
          st_d  = RX_IDLE;
        end else tc_d = tc_q + 1'b1;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      tc_q  <= '0;
      bn_q  <= '0;
      sh_q  <= '0;
      arm_q <= 1'b0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      s1_q  <= rxd;
      s2_q  <= s1_q;
      st_q  <= st_d;
      tc_q  <= tc_d;
      bn_q  <= bn_d;
      sh_q  <= sh_d;
      arm_q <= arm_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  // R5
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

// File: rtl/bootld_tx.sv
module bootld_tx
  import bootld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy
);
  logic [9:0] sh_q, sh_d;
  logic [3:0] tc_q, tc_d;
  logic [3:0] bn_q, bn_d;
  logic       bsy_q, bsy_d;

  assign busy = bsy_q;
  assign txd  = bsy_q ? sh_q[0] : 1'b1;

  always_comb begin
    sh_d  = sh_q;
    tc_d  = tc_q;
    bn_d  = bn_q;
    bsy_d = bsy_q;
    if (load && !bsy_q) begin
      sh_d  = {1'b1, din, 1'b0};
      tc_d  = '0;
      bn_d  = '0;
      bsy_d = 1'b1;
    end else if (bsy_q && tick) begin
      if (tc_q == 4'(OVERSAMPLE - 1)) begin
        tc_d = '0;
        sh_d = {1'b1, sh_q[9:1]};
        if (bn_q == 4'd9) bsy_d = 1'b0;
        else              bn_d  = bn_q + 1'b1;
      end else tc_d = tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      tc_q  <= '0;
      bn_q  <= '0;
      bsy_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      tc_q  <= tc_d;
      bn_q  <= bn_d;
      bsy_q <= bsy_d;
    end
  end

  // R9
  tx_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load));
  // R6
  tx_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/bootld_dma.sv
module bootld_dma
  import bootld_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMAGE_LEN  = 255,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_grant,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic              bus_req,
  output logic              dma_oe,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [7:0]        dma_data,
  output logic              dma_as,
  output logic              dma_ds,
  output logic              dma_wr,
  output logic              done
);
  localparam int SW = $clog2(STROBE_CYC + 1);

  ld_state_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        dat_q, dat_d;
  logic [SW-1:0]     sc_q, sc_d;
  logic              strobe;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    sc_d   = sc_q;
    unique case (st_q)
      LD_REQ:  if (bus_grant) st_d = LD_WAIT;
      LD_WAIT: if (byte_valid) begin
        dat_d = byte_in;
        sc_d  = '0;
        st_d  = LD_WRITE;
      end
      LD_WRITE: begin
        sc_d = sc_q + 1'b1;
        if (sc_q == SW'(STROBE_CYC - 1)) st_d = LD_GAP;
      end
      LD_GAP: begin
        addr_d = addr_q + 1'b1;
        st_d   = (addr_q == ADDR_W'(IMAGE_LEN - 1)) ? LD_DONE : LD_WAIT;
      end
      LD_DONE: st_d = LD_DONE;
      default: st_d = LD_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_REQ;
      addr_q <= '0;
      dat_q  <= '0;
      sc_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
      sc_q   <= sc_d;
    end
  end

  assign strobe   = (st_q == LD_WRITE);
  assign bus_req  = (st_q != LD_DONE);
  assign dma_oe   = (st_q == LD_WAIT) || (st_q == LD_WRITE) || (st_q == LD_GAP);
  assign dma_as   = strobe;
  assign dma_ds   = strobe;
  assign dma_wr   = strobe;
  assign dma_addr = addr_q;
  assign dma_data = dat_q;
  assign done     = (st_q == LD_DONE);

  // R2
  strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_as |-> (dma_oe && bus_grant && bus_req));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_addr) |-> (dma_addr == ADDR_W'($past(dma_addr) + 1'b1)));
  // R3
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_addr) |-> (!$past(dma_as) && !dma_as));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !bus_req && !dma_oe));
endmodule

// File: rtl/boot_dma_loader.sv
module boot_dma_loader #(
  parameter int CLK_DIV    = 54,
  parameter int ADDR_W     = 32,
  parameter int IMAGE_LEN  = 255,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              txd,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              dma_oe,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [7:0]        dma_data,
  output logic              dma_as,
  output logic              dma_ds,
  output logic              dma_wr,
  output logic              boot_done,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic       tick;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_busy;
  logic       tx_load;
  logic       rdy_q, rdy_d;
  logic [7:0] hold_q, hold_d;
  logic       sw_rx;

  bootld_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  bootld_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .valid(rx_valid), .data(rx_byte));

  bootld_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
    .din(reg_wdata), .txd(txd), .busy(tx_busy));

  bootld_dma #(
    .ADDR_W(ADDR_W), .IMAGE_LEN(IMAGE_LEN), .STROBE_CYC(STROBE_CYC)
  ) u_dma (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
    .byte_valid(rx_valid && !boot_done), .byte_in(rx_byte),
    .bus_req(bus_req), .dma_oe(dma_oe), .dma_addr(dma_addr),
    .dma_data(dma_data), .dma_as(dma_as), .dma_ds(dma_ds),
    .dma_wr(dma_wr), .done(boot_done));

  assign sw_rx   = rx_valid && boot_done;
  assign tx_load = reg_wr && !reg_addr && !tx_busy;

  always_comb begin
    rdy_d  = rdy_q;
    hold_d = hold_q;
    if (reg_rd && !reg_addr) rdy_d = 1'b0;
    if (sw_rx) begin
      rdy_d  = 1'b1;
      hold_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      hold_q <= hold_d;
    end
  end

  assign reg_rdata = reg_addr ? {6'b0, rdy_q, !tx_busy} : hold_q;

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_addr && !sw_rx) |=> !reg_rdata[1] || reg_addr);
  // R10
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> !rdy_q);
endmodule

// File: tb/tb_boot_dma_loader.sv
module tb_boot_dma_loader;
  localparam int DIV    = 2;
  localparam int AW     = 32;
  localparam int LEN    = 255;
  localparam int STB    = 3;
  localparam int BITC   = 16 * DIV;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rxd;
  logic          txd;
  logic          bus_grant;
  logic          bus_req;
  logic          dma_oe;
  logic [AW-1:0] dma_addr;
  logic [7:0]    dma_data;
  logic          dma_as, dma_ds, dma_wr;
  logic          boot_done;
  logic          reg_addr, reg_rd, reg_wr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;

  int checks = 0;
  int bad    = 0;
  int wcount = 0;
  int run    = 0;
  int exp_img [LEN];
  bit grant_en  = 1'b0;
  bit mon_en    = 1'b0;
  bit done_seen = 1'b0;
  bit prev_as   = 1'b0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  boot_dma_loader #(.CLK_DIV(DIV), .ADDR_W(AW), .IMAGE_LEN(LEN), .STROBE_CYC(STB)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .bus_grant(bus_grant),
    .bus_req(bus_req), .dma_oe(dma_oe), .dma_addr(dma_addr), .dma_data(dma_data),
    .dma_as(dma_as), .dma_ds(dma_ds), .dma_wr(dma_wr), .boot_done(boot_done),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = good_stop;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic grab_tx(output logic [7:0] b, output logic stopb);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BITC / 2) @(negedge clk);
    chk(txd == 1'b0, "R6 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      b[i] = txd;
    end
    repeat (BITC) @(negedge clk);
    stopb = txd;
  endtask

  // Grant model: answers a request after it is enabled, withdraws with it.
  always @(negedge clk) bus_grant <= grant_en && bus_req;

  // Per-clock reference model of the load stream.
  always @(negedge clk) begin
    if (mon_en) begin
      if ((dma_as || dma_ds || dma_wr) && !(dma_oe && bus_grant))
        chk(1'b0, "R2 strobe without ownership", dma_oe, 1);
      if (dma_oe && !bus_grant)
        chk(1'b0, "R2 drive without grant", bus_grant, 1);
      if (done_seen && (bus_req || dma_oe || dma_as))
        chk(1'b0, "R4 bus activity after release", {bus_req, dma_oe, dma_as}, 0);
      if (!done_seen && wcount < LEN && !bus_req)
        chk(1'b0, "R4 early release", wcount, LEN);
      if (dma_as && !prev_as) begin
        chk(!done_seen && wcount < LEN, "R4 write beyond image", wcount, LEN - 1);
        chk(dma_addr == AW'(wcount), "R3 address", dma_addr, wcount);
        if (wcount < LEN)
          chk(dma_data == 8'(exp_img[wcount]), "R3 data", dma_data, exp_img[wcount]);
        run = 1;
      end else if (dma_as) begin
        run++;
      end else if (prev_as) begin
        chk(run == STB, "R3 strobe width", run, STB);
        wcount++;
      end
      if (boot_done) done_seen = 1'b1;
      prev_as = dma_as;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wcount, LEN);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] tb_byte;
    logic       tb_stop;
    for (int i = 0; i < LEN; i++) exp_img[i] = (i * 37 + 11) & 8'hFF;
    rst_n = 1'b0; rxd = 1'b1; reg_addr = 1'b1; reg_rd = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0; bus_grant = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bus_req == 1'b1, "R1 request in reset", bus_req, 1);
    chk({dma_oe, dma_as, dma_ds, dma_wr} == 4'b0, "R1 idle drivers in reset", {dma_oe, dma_as, dma_ds, dma_wr}, 0);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(reg_rdata == 8'h01, "R7 status after reset", reg_rdata, 8'h01);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (40) @(negedge clk);
    // R1 no drive before grant
    chk(bus_req == 1'b1 && dma_oe == 1'b0, "R1 waiting for grant", {bus_req, dma_oe}, 2'b10);
    grant_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(dma_oe == 1'b1, "R2 drives once granted", dma_oe, 1);
    // R5 a framing error ahead of the image, mid image and before the last byte
    send_byte(8'h5A, 1'b0);
    for (int i = 0; i < LEN; i++) begin
      if (i == 100 || i == LEN - 1) send_byte(8'hC3, 1'b0);
      send_byte(8'(exp_img[i]), 1'b1);
    end
    repeat (8) @(negedge clk);
    chk(wcount == LEN, "R5 R3 write count with discarded frames", wcount, LEN);
    chk(boot_done == 1'b1, "R4 done flag", boot_done, 1);
    chk(bus_req == 1'b0 && dma_oe == 1'b0, "R4 bus released", {bus_req, dma_oe}, 0);
    chk(reg_rdata == 8'h01, "R10 no receive-ready from image bytes", reg_rdata, 8'h01);
    grant_en = 1'b0;
    // R7 R8 software receive
    send_byte(8'hA5, 1'b1);
    chk(reg_rdata == 8'h03, "R7 status with byte waiting", reg_rdata, 8'h03);
    chk(wcount == LEN, "R4 no write after release", wcount, LEN);
    reg_addr = 1'b0; reg_rd = 1'b1;
    #1;
    chk(reg_rdata == 8'hA5, "R8 data read", reg_rdata, 8'hA5);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 1'b1;
    #1;
    chk(reg_rdata == 8'h01, "R8 ready cleared by read", reg_rdata, 8'h01);
    // R5 bad frame after boot
    send_byte(8'h99, 1'b0);
    chk(reg_rdata == 8'h01, "R5 bad frame ignored", reg_rdata, 8'h01);
    reg_addr = 1'b0;
    #1;
    chk(reg_rdata == 8'hA5, "R5 data kept after bad frame", reg_rdata, 8'hA5);
    // R9 R6 transmit
    fork
      grab_tx(tb_byte, tb_stop);
      begin
        @(negedge clk);
        reg_wdata = 8'h3C; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b1;
        #1;
        chk(reg_rdata == 8'h00, "R9 empty cleared", reg_rdata, 8'h00);
      end
    join
    chk(tb_byte == 8'h3C, "R6 transmitted byte", tb_byte, 8'h3C);
    chk(tb_stop == 1'b1, "R6 stop bit", tb_stop, 1);
    repeat (BITC) @(negedge clk);
    chk(reg_rdata == 8'h01, "R9 empty after frame", reg_rdata, 8'h01);
    fork
      grab_tx(tb_byte, tb_stop);
      begin
        @(negedge clk);
        reg_addr = 1'b0; reg_wdata = 8'h81; reg_wr = 1'b1;
        @(negedge clk);
        reg_wdata = 8'hFF;
        repeat (3 * BITC) @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b1;
      end
    join
    chk(tb_byte == 8'h81, "R9 busy write ignored", tb_byte, 8'h81);
    repeat (BITC) @(negedge clk);
    for (int k = 0; k < 2 * BITC; k++) begin
      if (txd !== 1'b1) chk(1'b0, "R9 no extra frame", txd, 1);
      @(negedge clk);
    end
    chk(txd == 1'b1 && reg_rdata == 8'h01, "R9 idle after ignored write", reg_rdata, 8'h01);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule